// File: doc/BRIEF.md
# Five-Channel PWM DAC with Binary Rate Multiplier

The block drives five output pins, each of which can carry either a pulse-width-modulated waveform or the value of an ordinary port latch. Every channel is set by one 8-bit data byte. The upper five bits give the width of a high pulse inside a period of 32 PWM clocks. The lower three bits give a count of narrow one-clock extensions, and these extensions are spread over a frame of eight PWM periods. After low-pass filtering, the pin average therefore has 256 levels. The repetition rate stays that of a 5-bit PWM.

A single 2-bit divider select sets the PWM clock for all channels, at 1/2, 1/4, 1/8 or 1/16 of the system clock. Data bytes and the divider select are copied into working shadows only at a frame boundary, so a frame is always generated from one consistent setting. The per-pin enables act at once.

Top module: `pwm_brm_dac`

## Requirements
- R1: The PWM clock advances once every 2^(s+1) system clocks, where s is the divider select (0 to 3). One frame is therefore 256·2^(s+1) system clocks long.
- R2: A PWM period is 32 PWM clocks, numbered 0 to 31. An enabled pin is high in the slots whose number is below the effective width. The effective width is data bits 7:3, plus one when the period is extended.
- R3: In each frame of 8 periods, exactly as many periods are extended as data bits 2:0 give. The high time over a frame is therefore 2^(s+1)·(8·width + count) system clocks.
- R4: Periods are numbered 0 to 7 within the frame. Count bit 2 extends periods 1, 3, 5 and 7. Count bit 1 extends periods 2 and 6. Count bit 0 extends period 4.
- R5: Data bytes and the divider select written during a frame take effect from the first system clock of the next frame, and never earlier.
- R6: Channel k is enabled by bit k+3 of the port configuration byte. A disabled pin shows gpio_lat[k]. An enable write affects the pin from the clock after it is written.
- R7: Reset clears all data bytes, the divider select and all enables. The pins then follow gpio_lat, and the first frame after reset runs with divide-by-2 and all-zero data.
- R8: Width 0 with count 0 holds an enabled pin low. Width 31 in an extended period holds the pin high for the whole period.
- R9: Write addresses 0 to 4 select the channel data bytes. Address 5 selects the divider, using bits 1:0 and ignoring the rest. Address 6 selects the port configuration byte. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| gpio_lat | input | 5 | Port latch values shown on disabled pins |
| pin_out | output | 5 | Pin values, PWM or port latch per channel |

## Verification
The first frames use fixed patterns that separate the extremes: the half-scale byte 83h at both the fastest and the slowest divider, zero and full-scale widths with and without extensions, and a width of 1 with extensions. These show whether the slot comparison, the extension slot and the full-period case are right. Further frames sweep computed bytes across all four divider settings. Each pin is compared on every system clock against an arithmetic model built from the slot and period indices, so an early or late shadow load, a wrong divide ratio or a misplaced extension gives a miscompare at a specific slot. The per-frame high-time totals check the extension count, independent of where the extensions fall. Enable masks change part way through frames, while the port latch toggles pseudo-randomly, which tells the mux timing apart from the PWM path.

// File: rtl/pwm_brm_dac.sv
module pwm_brm_dac #(
  parameter int NCH    = 5,
  parameter int DUTY_W = 5,
  parameter int BRM_W  = 3,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NCH-1:0]    gpio_lat,
  output logic [NCH-1:0]    pin_out
);
  localparam int DW     = DUTY_W + BRM_W;
  localparam int PRE_W  = 2 ** SEL_W;
  localparam int EN_LSB = DW - NCH;

  logic [NCH-1:0][DW-1:0] data_q, data_s;
  logic [SEL_W-1:0]       sel_q, sel_s;
  logic [NCH-1:0]         en_q, pwm_q, pwm_d;
  logic [PRE_W-1:0]       pre_cnt, pre_mask;
  logic [DUTY_W-1:0]      slot;
  logic [BRM_W-1:0]       cyc;
  logic                   tick, frame_end;

  assign pre_mask  = ~({PRE_W{1'b1}} << ({1'b0, sel_s} + 1'b1));
  assign tick      = (pre_cnt & pre_mask) == pre_mask;
  assign frame_end = tick && (&slot) && (&cyc);
  assign pin_out   = (en_q & pwm_q) | (~en_q & gpio_lat);

  function automatic logic brm_hit(input logic [BRM_W-1:0] cnt, input logic [BRM_W-1:0] c);
    logic h;
    h = 1'b0;
    for (int i = 0; i < BRM_W; i++) begin
      int p;
      p = BRM_W - 1 - i;
      if (cnt[i] && ((int'(c) & ((1 << (p + 1)) - 1)) == (1 << p))) h = 1'b1;
    end
    return h;
  endfunction

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      logic [DUTY_W:0] thr;
      thr = {1'b0, data_s[k][DW-1:BRM_W]} + {{DUTY_W{1'b0}}, brm_hit(data_s[k][BRM_W-1:0], cyc)};
      pwm_d[k] = {1'b0, slot} < thr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      slot    <= '0;
      cyc     <= '0;
      data_q  <= '0;
      data_s  <= '0;
      sel_q   <= '0;
      sel_s   <= '0;
      en_q    <= '0;
      pwm_q   <= '0;
    end else begin
      pre_cnt <= frame_end ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        slot <= slot + 1'b1;
        if (&slot) cyc <= cyc + 1'b1;
      end
      if (frame_end) begin
        data_s <= data_q;
        sel_s  <= sel_q;
      end
      pwm_q <= pwm_d;
      if (wr_en) begin
        for (int k = 0; k < NCH; k++)
          if (wr_addr == ADDR_W'(k)) data_q[k] <= wr_data[DW-1:0];
        if (wr_addr == ADDR_W'(NCH))     sel_q <= wr_data[SEL_W-1:0];
        if (wr_addr == ADDR_W'(NCH + 1)) en_q  <= wr_data[DW-1:EN_LSB];
      end
    end
  end
endmodule

// File: rtl/pwm_brm_dac_chk.sv
module pwm_brm_dac_chk #(
  parameter int NCH    = 5,
  parameter int DUTY_W = 5,
  parameter int BRM_W  = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tick,
  input logic                           frame_end,
  input logic [DUTY_W-1:0]              slot,
  input logic [BRM_W-1:0]               cyc,
  input logic [NCH-1:0][DUTY_W+BRM_W-1:0] shd,
  input logic [NCH-1:0]                 pwm
);
  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot));

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot != '1) |=> $stable(cyc));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(shd));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    // R8
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shd[k] == '0) |=> !pwm[k]);
  end
endmodule

bind pwm_brm_dac pwm_brm_dac_chk #(.NCH(NCH), .DUTY_W(DUTY_W), .BRM_W(BRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .frame_end(frame_end),
  .slot(slot), .cyc(cyc), .shd(data_s), .pwm(pwm_q)
);

// File: tb/sim_pwm_brm_dac.sv
module sim_pwm_brm_dac;
  localparam int P       = 10;
  localparam int NCH     = 5;
  localparam int NFRAMES = 30;

  logic           clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] gpio = '0;
  logic [NCH-1:0] pin;
  logic [15:0]    lfsr = 16'hACE1;
  logic [NCH-1:0] en_now = '0;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #(P/2) clk = ~clk;

  pwm_brm_dac u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .gpio_lat(gpio), .pin_out(pin));

  task automatic chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int get_data(int n, int k);
    int t1 [5] = '{8'h83, 8'h00, 8'hF8, 8'hFF, 8'h0D};
    int t2 [5] = '{8'h83, 8'h07, 8'h01, 8'h80, 8'hFE};
    int t3 [5] = '{8'h00, 8'h10, 8'h55, 8'hAA, 8'h1F};
    if (n == 0) return 0;
    if (n == 1) return t1[k];
    if (n == 2) return t2[k];
    if (n == 3) return t3[k];
    return (n * 29 + k * 71 + 3) & 8'hFF;
  endfunction

  function automatic int get_sel(int n);
    if (n == 0) return 0;
    if (n == 1) return 0;
    if (n == 2) return 3;
    if (n == 3) return 1;
    return n % 4;
  endfunction

  function automatic logic [NCH-1:0] get_en(int n);
    if (n == 3) return 5'b10101;
    if (n >= 4 && n % 3 == 0) return ~(5'b00001 << (n % 5));
    return 5'b11111;
  endfunction

  // R4: bit 2 -> odd periods, bit 1 -> periods 2 and 6, bit 0 -> period 4
  function automatic bit hit(int b, int c);
    return (b[2] && (c % 2 == 1)) || (b[1] && (c % 4 == 2)) || (b[0] && c == 4);
  endfunction

  task automatic run_frame(int n);
    int div, total;
    int cnt [NCH];
    logic [NCH-1:0] en_start, en_next;
    div      = 2 << get_sel(n);
    total    = 256 * div;
    en_start = en_now;
    en_next  = get_en(n + 1);
    for (int k = 0; k < NCH; k++) cnt[k] = 0;
    for (int j = 0; j < total; j++) begin
      int pos, slot, c;
      @(posedge clk);
      @(negedge clk);
      if (j == 7) en_now = en_next;
      pos  = j / div;
      slot = pos % 32;
      c    = pos / 32;
      for (int k = 0; k < NCH; k++) begin
        int d, w, b, e;
        string tag;
        d = get_data(n, k);
        w = d >> 3;
        b = d & 7;
        e = en_now[k] ? int'(slot < w + int'(hit(b, c))) : int'(gpio[k]);
        if (!en_now[k])                 tag = "R6 port latch";
        else if (n == 0)                tag = "R7 post-reset frame";
        else if (n == 4)                tag = "R9 after address-7 write";
        else if (d == 0)                tag = "R8 zero setting";
        else if (hit(b, c) && slot == w) tag = "R4 extension slot";
        else if (pos < 32)              tag = "R5 first period of frame";
        else                            tag = "R2 pulse width";
        chk(pin[k] === e[0], tag, int'(pin[k]), e);
        if (en_start[k] && en_next[k] && pin[k]) cnt[k]++;
      end
      wr_en = 1'b0;
      if (j < 7) begin
        wr_en   = 1'b1;
        wr_addr = 3'(j);
        if (j < 5)       wr_data = 8'(get_data(n + 1, j));
        else if (j == 5) wr_data = {6'b101010, 2'(get_sel(n + 1))};
        else             wr_data = {en_next, 3'b000};
      end else if (j == 7 && n == 3) begin
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'hFF;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gpio = lfsr[4:0];
    end
    for (int k = 0; k < NCH; k++)
      if (en_start[k] && en_next[k]) begin
        int d, exp;
        d   = get_data(n, k);
        exp = div * (8 * (d >> 3) + (d & 7));
        chk(cnt[k] == exp, "R1 R3 frame high time", cnt[k], exp);
      end
  endtask

  initial begin
    gpio = 5'b10110;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pin === gpio, "R7 reset pins follow latch", int'(pin), int'(gpio));
    gpio = 5'b01001;
    #1 chk(pin === gpio, "R7 reset pins follow latch", int'(pin), int'(gpio));
    rst_n = 1'b1;
    for (int n = 0; n < NFRAMES; n++) run_frame(n);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(P * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule